// File: doc/BRIEF.md
# Systolic 8-bit Matrix Multiply Engine

This block multiplies a small signed 8-bit matrix A (M rows, K columns) by a signed 8-bit matrix B (K rows, N columns). The work is done on a 4x4 grid of multiply-accumulate cells wired as a two-dimensional systolic array. Operands are held in two external word-addressed buffers, 32 bits wide, with four elements packed in each word. A is stored column by column, so buffer word t carries column t of A. B is stored row by row, so buffer word t carries row t of B. One read of each buffer per cycle therefore delivers one full wavefront of the array.

A one-cycle start pulse launches a run. The engine captures the shape, streams K operand words from each buffer, skews them into the array edges and lets the last wavefront settle. It then writes one result word per row of C into a third buffer and pulses done. Each result element is the low byte of its exact dot product.

Top module: `mmx_systolic`

## Requirements
- R1: With the engine idle, a start pulse captures dim_m and dim_n (each 1..4) and dim_k (1..256). A start pulse, or any change on the dimension inputs, while a run is in progress has no effect on that run.
- R2: A run issues exactly dim_k reads with rd_en high, at addresses 0, 1, ..., dim_k-1 in ascending order, with a_addr equal to b_addr. Read data is taken one cycle after the address. Byte i (bits 8i+7:8i) of A word t is A[i][t]. Byte j of B word t is B[t][j].
- R3: Operands are two's-complement signed. Each result element is the exact sum over t of A[i][t]*B[t][j], truncated to its low 8 bits.
- R4: Result row i is written to output address i for i = 0..dim_m-1, with byte j holding C[i][j]. No other address is written. Bytes j >= dim_n of each result word are zero.
- R5: Bytes of operand words that lie outside the captured M (for A) or N (for B) lanes do not affect any result.
- R6: done is high for exactly one cycle, directly after the last result write. No write occurs while done is high.
- R7: If start is sampled in cycle s, done is high in cycle s + dim_k + dim_m + 8.
- R8: Accumulators are cleared at the end of each run, so back-to-back runs give independent results.
- R9: While reset is high, done, c_we and rd_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request pulse, honoured only when idle |
| dim_m | input | 3 | Rows of A and of C |
| dim_n | input | 3 | Columns of B and of C |
| dim_k | input | 9 | Shared inner dimension |
| rd_en | output | 1 | Read strobe for both operand buffers |
| a_addr | output | 8 | Word address into the A buffer |
| a_rdata | input | 32 | A buffer read data, one cycle after the address |
| b_addr | output | 8 | Word address into the B buffer |
| b_rdata | input | 32 | B buffer read data, one cycle after the address |
| c_we | output | 1 | Result buffer write enable |
| c_addr | output | 8 | Result buffer word address (row index) |
| c_wdata | output | 32 | Packed result row |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every combination of M and N from 1 to 4 is run with random operands. This separates lane masking and output packing errors from arithmetic errors. Square runs at K = 2, 4 and 9 check the main shapes. A run at K = 256 with all operands at -128 drives the largest positive sum, whose low byte is zero, so it exposes accumulator width and truncation mistakes. An alternating extreme pattern and a small-value pattern catch sign-extension faults and skew misalignment between rows and columns. Unused operand lanes are filled with junk to show they are masked. A start pulse with other dimensions is injected in the middle of a run to show it is ignored, and consecutive runs show that the accumulators are cleared.

// File: rtl/mmx_pkg.sv
package mmx_pkg;
    localparam int DIM   = 4;
    localparam int DW    = 8;
    localparam int WW    = DIM * DW;
    localparam int AW    = 8;
    localparam int KW    = AW + 1;
    localparam int CW    = $clog2(DIM + 1);
    localparam int RW    = $clog2(DIM);
    localparam int ACC_W = 2 * DW + AW;
    localparam int FLUSH = 2 * DIM - 1;

    typedef logic signed [DW-1:0]    elem_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FEED, ST_FLUSH, ST_DRAIN, ST_DONE
    } state_e;

    typedef struct packed {
        logic [CW-1:0] m;
        logic [CW-1:0] n;
        logic [KW-1:0] k;
    } dims_t;

    function automatic elem_t lane_of(input logic [WW-1:0] w, input int idx);
        return elem_t'(w[idx*DW +: DW]);
    endfunction
endpackage

// File: rtl/mmx_ctrl.sv
module mmx_ctrl
    import mmx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  dims_t         dims_in,
    output dims_t         dims_q,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [RW-1:0] wr_row,
    output logic          acc_clr,
    output logic          done
);
    state_e        state;
    logic [KW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            dims_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    dims_q <= dims_in;
                    cnt    <= '0;
                    state  <= ST_FEED;
                end
                ST_FEED: if (cnt == dims_q.k - KW'(1)) begin
                    cnt   <= '0;
                    state <= ST_FLUSH;
                end else cnt <= cnt + KW'(1);
                ST_FLUSH: if (cnt == KW'(FLUSH - 1)) begin
                    cnt   <= '0;
                    state <= ST_DRAIN;
                end else cnt <= cnt + KW'(1);
                ST_DRAIN: if (cnt == KW'(dims_q.m) - KW'(1)) begin
                    cnt   <= '0;
                    state <= ST_DONE;
                end else cnt <= cnt + KW'(1);
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_en   = (state == ST_FEED);
    assign rd_addr = cnt[AW-1:0];
    assign wr_en   = (state == ST_DRAIN);
    assign wr_row  = cnt[RW-1:0];
    assign acc_clr = (state == ST_DONE);
    assign done    = (state == ST_DONE);
endmodule

// File: rtl/mmx_feed.sv
module mmx_feed
    import mmx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [WW-1:0] a_word,
    input  logic [WW-1:0] b_word,
    input  logic [CW-1:0] m,
    input  logic [CW-1:0] n,
    output elem_t         a_edge [DIM],
    output elem_t         b_edge [DIM]
);
    logic  vld_q;
    elem_t a_raw [DIM];
    elem_t b_raw [DIM];

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= rd_en;
    end

    always_comb begin
        for (int i = 0; i < DIM; i++) begin
            a_raw[i] = (vld_q && (CW'(i) < m)) ? lane_of(a_word, i) : '0;
            b_raw[i] = (vld_q && (CW'(i) < n)) ? lane_of(b_word, i) : '0;
        end
    end

    for (genvar gi = 0; gi < DIM; gi++) begin : g_skew
        if (gi == 0) begin : g_direct
            assign a_edge[gi] = a_raw[gi];
            assign b_edge[gi] = b_raw[gi];
        end else begin : g_delay
            elem_t a_sr [gi];
            elem_t b_sr [gi];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int s = 0; s < gi; s++) begin
                        a_sr[s] <= '0;
                        b_sr[s] <= '0;
                    end
                end else begin
                    a_sr[0] <= a_raw[gi];
                    b_sr[0] <= b_raw[gi];
                    for (int s = 1; s < gi; s++) begin
                        a_sr[s] <= a_sr[s-1];
                        b_sr[s] <= b_sr[s-1];
                    end
                end
            end
            assign a_edge[gi] = a_sr[gi-1];
            assign b_edge[gi] = b_sr[gi-1];
        end
    end
endmodule

// File: rtl/mmx_pe.sv
module mmx_pe
    import mmx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  elem_t a_in,
    input  elem_t b_in,
    output acc_t  acc
);
    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else            acc <= acc + acc_t'(a_in) * acc_t'(b_in);
    end
endmodule

// File: rtl/mmx_systolic.sv
module mmx_systolic
    import mmx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] dim_m,
    input  logic [CW-1:0] dim_n,
    input  logic [KW-1:0] dim_k,
    output logic          rd_en,
    output logic [AW-1:0] a_addr,
    input  logic [WW-1:0] a_rdata,
    output logic [AW-1:0] b_addr,
    input  logic [WW-1:0] b_rdata,
    output logic          c_we,
    output logic [AW-1:0] c_addr,
    output logic [WW-1:0] c_wdata,
    output logic          done
);
    dims_t         dims_in;
    dims_t         dims_q;
    logic [AW-1:0] rd_addr;
    logic [RW-1:0] wr_row;
    logic          acc_clr;
    elem_t         a_edge [DIM];
    elem_t         b_edge [DIM];
    elem_t         a_h    [DIM][DIM];
    elem_t         b_v    [DIM][DIM];
    acc_t          acc    [DIM][DIM];
    logic [DIM*DIM-1:0] acc_nz_v;
    logic          acc_any;

    assign dims_in = '{m: dim_m, n: dim_n, k: dim_k};

    mmx_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .dims_in(dims_in),
        .dims_q(dims_q), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(c_we), .wr_row(wr_row), .acc_clr(acc_clr), .done(done)
    );

    assign a_addr = rd_addr;
    assign b_addr = rd_addr;

    mmx_feed u_feed (
        .clk(clk), .rst(rst), .rd_en(rd_en),
        .a_word(a_rdata), .b_word(b_rdata),
        .m(dims_q.m), .n(dims_q.n),
        .a_edge(a_edge), .b_edge(b_edge)
    );

    for (genvar gr = 0; gr < DIM; gr++) begin : g_row
        for (genvar gc = 0; gc < DIM; gc++) begin : g_col
            if (gc == 0) begin : g_aedge
                assign a_h[gr][gc] = a_edge[gr];
            end else begin : g_apipe
                always_ff @(posedge clk) begin
                    if (rst) a_h[gr][gc] <= '0;
                    else     a_h[gr][gc] <= a_h[gr][gc-1];
                end
            end
            if (gr == 0) begin : g_bedge
                assign b_v[gr][gc] = b_edge[gc];
            end else begin : g_bpipe
                always_ff @(posedge clk) begin
                    if (rst) b_v[gr][gc] <= '0;
                    else     b_v[gr][gc] <= b_v[gr-1][gc];
                end
            end
            mmx_pe u_pe (
                .clk(clk), .rst(rst), .clr(acc_clr),
                .a_in(a_h[gr][gc]), .b_in(b_v[gr][gc]),
                .acc(acc[gr][gc])
            );
            assign acc_nz_v[gr*DIM+gc] = |acc[gr][gc];
        end
    end

    assign acc_any = |acc_nz_v;
    assign c_addr  = AW'(wr_row);

    always_comb begin
        c_wdata = '0;
        for (int j = 0; j < DIM; j++) begin
            if (CW'(j) < dims_q.n) c_wdata[j*DW +: DW] = acc[wr_row][j][DW-1:0];
        end
    end
endmodule

// File: rtl/mmx_systolic_chk.sv
module mmx_systolic_chk
    import mmx_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic [AW-1:0] a_addr,
    input logic [AW-1:0] b_addr,
    input logic          c_we,
    input logic [AW-1:0] c_addr,
    input logic          done,
    input logic          acc_any,
    input logic [KW-1:0] k_q
);
    logic [KW-1:0] rd_num;

    always_ff @(posedge clk) begin
        if (rst || done) rd_num <= '0;
        else if (rd_en)  rd_num <= rd_num + KW'(1);
    end

    AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (rst) done |=> !done);                  // R6
    AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> $past(c_we));   // R6
    AST_NO_WR_DONE:  assert property (@(posedge clk) disable iff (rst) done |-> !c_we);                  // R6
    AST_ROW_RANGE:   assert property (@(posedge clk) disable iff (rst) c_we |-> (c_addr < AW'(DIM)));    // R4
    AST_RD_FIRST:    assert property (@(posedge clk) disable iff (rst) $rose(rd_en) |-> (a_addr == '0 && b_addr == '0)); // R2
    AST_RD_STEP:     assert property (@(posedge clk) disable iff (rst)
                         (rd_en && $past(rd_en)) |-> (a_addr == $past(a_addr) + AW'(1)));                 // R2
    AST_RD_COUNT:    assert property (@(posedge clk) disable iff (rst) done |-> (rd_num == k_q));         // R2
    AST_ACC_CLEAR:   assert property (@(posedge clk) disable iff (rst) done |=> !acc_any);                // R8
endmodule

bind mmx_systolic mmx_systolic_chk u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .a_addr(a_addr), .b_addr(b_addr),
    .c_we(c_we), .c_addr(c_addr), .done(done), .acc_any(acc_any), .k_q(dims_q.k)
);

// File: tb/sim_mmx_systolic.sv
`timescale 1ns/1ps
module sim_mmx_systolic;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  dim_m, dim_n;
    logic [8:0]  dim_k;
    logic        rd_en, c_we, done;
    logic [7:0]  a_addr, b_addr, c_addr;
    logic [31:0] a_rdata, b_rdata, c_wdata;

    logic [31:0] mem_a [256];
    logic [31:0] mem_b [256];
    logic [31:0] mem_c [256];
    logic        clr_req;
    int          wr_num, rd_num, rd_bad, rd_exp;
    int          ea [4][256];
    int          eb [256][4];
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    mmx_systolic u0 (
        .clk(clk), .rst(rst), .start(start), .dim_m(dim_m), .dim_n(dim_n), .dim_k(dim_k),
        .rd_en(rd_en), .a_addr(a_addr), .a_rdata(a_rdata), .b_addr(b_addr), .b_rdata(b_rdata),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .done(done)
    );

    always @(posedge clk) begin
        a_rdata <= mem_a[a_addr];
        b_rdata <= mem_b[b_addr];
        if (clr_req) begin
            for (int x = 0; x < 256; x++) mem_c[x] <= 32'hDEAD_BEEF;
            wr_num <= 0; rd_num <= 0; rd_bad <= 0; rd_exp <= 0;
        end else begin
            if (c_we) begin
                mem_c[c_addr] <= c_wdata;
                wr_num <= wr_num + 1;
            end
            if (rd_en) begin
                if (int'(a_addr) != rd_exp || int'(b_addr) != rd_exp) rd_bad <= rd_bad + 1;
                rd_exp <= rd_exp + 1;
                rd_num <= rd_num + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int gen(input int mode, input int side, input int r, input int t);
        case (mode)
            0:       return int'($urandom % 256) - 128;
            1:       return -128;
            2:       return ((r + t + side) % 2 == 1) ? 127 : -128;
            default: return (r + 2 * t + side) % 5 - 2;
        endcase
    endfunction

    task automatic fill(input int m, input int n, input int k, input int mode);
        for (int t = 0; t < k; t++) begin
            logic [31:0] wa, wb;
            for (int i = 0; i < 4; i++) begin
                int va, vb;
                va = (i < m) ? gen(mode, 0, i, t) : int'($urandom % 256);
                vb = (i < n) ? gen(mode, 1, i, t) : int'($urandom % 256);
                wa[8*i +: 8] = va[7:0];
                wb[8*i +: 8] = vb[7:0];
                ea[i][t] = int'($signed(va[7:0]));
                eb[t][i] = int'($signed(vb[7:0]));
            end
            mem_a[t] = wa;
            mem_b[t] = wb;
        end
    endtask

    task automatic run(input int m, input int n, input int k, input int mode, input bit poke);
        int cyc;
        fill(m, n, k, mode);
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
        dim_m = 3'(m); dim_n = 3'(n); dim_k = 9'(k); start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        if (poke) begin dim_m = 3'd1; dim_n = 3'd1; dim_k = 9'd1; end
        cyc = 1;
        while (!done && cyc < 5000) begin
            if (poke) start = (cyc == 3);
            @(posedge clk); @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        // R7 latency, R1 busy start ignored when poke set
        chk($sformatf("R7 latency m%0d n%0d k%0d", m, n, k), cyc, k + m + 8);
        chk("R4 write count", wr_num, m);
        chk("R2 read count", rd_num, k);
        chk("R2 read order", rd_bad, 0);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] exp;
            if (i < m) begin
                exp = '0;
                for (int j = 0; j < n; j++) begin
                    int s = 0;
                    for (int t = 0; t < k; t++) s += ea[i][t] * eb[t][j];
                    exp[8*j +: 8] = s[7:0];
                end
                chk($sformatf("R3 R5 row %0d m%0d n%0d k%0d mode%0d", i, m, n, k, mode), mem_c[i], exp);
            end else begin
                chk($sformatf("R4 row %0d unwritten", i), mem_c[i], 32'hDEAD_BEEF);
            end
        end
        @(posedge clk); @(negedge clk);
        chk("R6 done single cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; clr_req = 1'b0;
        dim_m = '0; dim_n = '0; dim_k = '0;
        for (int x = 0; x < 256; x++) begin mem_a[x] = '0; mem_b[x] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset outputs", {29'd0, done, c_we, rd_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 idle outputs", {29'd0, done, c_we, rd_en}, 32'd0);
        run(2, 2, 2, 0, 1'b0);
        run(4, 4, 4, 0, 1'b0);
        run(4, 4, 9, 0, 1'b0);
        run(4, 4, 256, 1, 1'b0);   // R3 wrap of largest sum
        run(4, 4, 256, 2, 1'b0);
        run(4, 4, 7, 3, 1'b1);     // R1 start while busy
        run(3, 4, 5, 3, 1'b0);     // R8 back to back
        for (int m = 1; m <= 4; m++)
            for (int n = 1; n <= 4; n++)
                run(m, n, 3, 0, 1'b0);
        run(4, 4, 1, 0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule